// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This unit is the system-control register block beside a small 32-bit processor core. It watches for synchronous exception requests from the pipeline and for hardware interrupt lines, decides in the current cycle whether fetch must be redirected, and records what happened. On every redirect it saves the PC of the affected instruction and the reason, and pushes a three-level stack of (mode, interrupt-enable) pairs so that the handler starts in kernel mode with interrupts off. A return strobe pops that stack again.

The core redirects fetch to a single fixed handler address whenever the take pulse is high. In the same cycle it must drop the register writeback of the instruction that raised a synchronous exception. Software reads and writes the unit's registers through a small move-to / move-from port: a 5-bit register number, a write strobe, write data and combinational read data.

Interrupt lines are sticky. A line that rises while interrupts are disabled stays pending until it is taken. When an interrupt is taken, the unit acknowledges exactly one hardware line: the highest-numbered one that is both pending and allowed.

Top module: `trapCoproc`

## Requirements
- R1: After reset every readable register returns 0, the unit is in kernel mode (userMode=0) and interrupts are disabled (intEn=0).
- R2: When takeExc is high, at the next clock the mode/enable stack (Status bits [5:0]) becomes its old bits [3:0] shifted up by two with bits [1:0]=00. userMode is Status[1] and intEn is Status[0]; in each pair the mode bit is upper (1 = user) and the enable bit is lower (1 = enabled).
- R3: A retExc strobe sets the stack to {S[5:4], S[5:2]}. It is ignored in a cycle where takeExc is high.
- R4: On every take, register 14 captures instrPc. handlerPc is always 0x80000080.
- R5: Cause bits [5:2] hold the code of the last take. A synchronous exception stores excCode (4 load/fetch address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 system call, 9 breakpoint, 10 reserved instruction, 12 overflow). An interrupt stores 0.
- R6: Register 8 captures faultAddr only on a synchronous exception with code 4 or 5. Otherwise it is unchanged.
- R7: squashWb equals excReq, and takeExc is high in every cycle where excReq is high.
- R8: An interrupt is taken only when instrBoundary=1, intEn=1 and some pending bit is allowed by its mask bit. Hardware line i is pending at Cause bit 10+i and masked by Status bit 10+i. Software bit j is at Cause bit 8+j and masked by Status bit 8+j. Status bit 15 has no effect.
- R9: A hardware pending bit is set in the cycle after its line is high. It stays set after the line drops, including while interrupts are disabled.
- R10: When an interrupt is taken, the highest-numbered hardware line that is pending and allowed has its pending bit cleared. If the line is still high, the bit sets again.
- R11: When excReq and a takeable interrupt arrive in the same cycle, the synchronous exception wins: its code is stored and no pending bit is acknowledged.
- R12: A write to register 12 loads mask bits [15:8] and stack bits [5:0]; the stack load loses to a take or a return in the same cycle. A write to register 13 loads only software pending bits [9:8]. Writes to any other number, and all writes in a takeExc cycle, are ignored. Unused bits read as 0.
- R13: regRdata returns the selected register's current value combinationally in the same cycle as regAddr. Register 8 is the faulting address, 12 status, 13 cause, 14 exception PC; any other number reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excReq | input | 1 | Synchronous exception request for the current instruction |
| excCode | input | 4 | Cause code of the request |
| instrPc | input | 32 | PC of the current instruction |
| faultAddr | input | 32 | Data address of a faulting access |
| hwIrq | input | 5 | Hardware interrupt lines |
| instrBoundary | input | 1 | High when an interrupt may be taken this cycle |
| retExc | input | 1 | Return-from-exception strobe |
| regAddr | input | 5 | Register number for move-to / move-from |
| regWe | input | 1 | Move-to write strobe |
| regWdata | input | 32 | Move-to write data |
| regRdata | output | 32 | Move-from read data |
| takeExc | output | 1 | Redirect fetch this cycle |
| handlerPc | output | 32 | Redirect target |
| squashWb | output | 1 | Suppress writeback of the current instruction |
| userMode | output | 1 | Current mode, 1 = user |
| intEn | output | 1 | Current interrupt enable |

## Verification
Two pairs of functions can collide in one cycle. The first is a synchronous exception and a takeable interrupt, provoked by driving excReq while a line is pending, allowed and enabled at an instruction boundary. The second is a return strobe together with a take. The bench judges each collision by reading back the stored code, the pending bits and the stack. The exception code must appear, the pending line must survive, and the stack must show a single push with no pop. Random traffic then mixes requests, returns, boundaries, lines and register writes, and a bench model predicts the take pulse and every readback.

// File: rtl/excPkg.sv
package excPkg;
  localparam int REG_BAD    = 8;
  localparam int REG_STATUS = 12;
  localparam int REG_CAUSE  = 13;
  localparam int REG_EPC    = 14;

  localparam logic [3:0] CODE_IRQ      = 4'd0;
  localparam logic [3:0] CODE_ADR_LOAD = 4'd4;
  localparam logic [3:0] CODE_ADR_STOR = 4'd5;

  typedef struct packed {
    logic       takeSync;
    logic       takeIrq;
    logic       doRet;
    logic       wrStatus;
    logic       wrCause;
    logic [4:0] ackLine;
  } ctrlStrobes_t;
endpackage

// File: rtl/excControl.sv
module excControl
  import excPkg::*;
#(
  parameter int HW = 5,
  parameter int SW = 2,
  parameter int AW = 5
) (
  input  logic              excReq,
  input  logic              instrBoundary,
  input  logic              retExc,
  input  logic              regWe,
  input  logic [AW-1:0]     regAddr,
  input  logic              curEn,
  input  logic [HW+SW-1:0]  maskLow,
  input  logic [HW-1:0]     hwPend,
  input  logic [SW-1:0]     swPend,
  output ctrlStrobes_t      str,
  output logic              takeExc
);
  logic [HW+SW-1:0] allowed;
  logic [HW-1:0]    hwAvail;
  logic [HW-1:0]    ackOne;
  logic             irqTake;

  assign allowed = {hwPend, swPend} & maskLow;
  assign hwAvail = hwPend & maskLow[SW +: HW];
  assign irqTake = instrBoundary & curEn & (|allowed) & ~excReq;
  assign takeExc = excReq | irqTake;

  // highest-numbered allowed hardware line wins the acknowledge
  always_comb begin
    ackOne = '0;
    for (int i = 0; i < HW; i++) begin
      if (hwAvail[i]) ackOne = {{(HW-1){1'b0}}, 1'b1} << i;
    end
  end

  always_comb begin
    str          = '0;
    str.takeSync = excReq;
    str.takeIrq  = irqTake;
    str.doRet    = retExc & ~takeExc;
    str.wrStatus = regWe & ~takeExc & (regAddr == AW'(REG_STATUS));
    str.wrCause  = regWe & ~takeExc & (regAddr == AW'(REG_CAUSE));
    str.ackLine  = irqTake ? ackOne : '0;
  end
endmodule

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
#(
  parameter int XLEN = 32,
  parameter int HW   = 5,
  parameter int SW   = 2,
  parameter int MW   = 8,
  parameter int CW   = 4,
  parameter int AW   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     str,
  input  logic [CW-1:0]    excCode,
  input  logic [XLEN-1:0]  instrPc,
  input  logic [XLEN-1:0]  faultAddr,
  input  logic [HW-1:0]    hwIrq,
  input  logic [AW-1:0]    regAddr,
  input  logic [XLEN-1:0]  regWdata,
  output logic [XLEN-1:0]  regRdata,
  output logic [5:0]       stackQ,
  output logic [MW-1:0]    maskQ,
  output logic [HW-1:0]    hwPendQ,
  output logic [SW-1:0]    swPendQ,
  output logic [CW-1:0]    codeQ
);
  localparam int MASK_LSB = 8;
  localparam int CODE_LSB = 2;
  localparam int SWP_LSB  = 8;
  localparam int HWP_LSB  = SWP_LSB + SW;

  logic [XLEN-1:0] epcQ;
  logic [XLEN-1:0] badQ;
  logic [XLEN-1:0] statusWord;
  logic [XLEN-1:0] causeWord;
  logic            anyTake;
  logic            unusedWdata;

  assign anyTake     = str.takeSync | str.takeIrq;
  assign unusedWdata = ^{regWdata[XLEN-1:MASK_LSB+MW], regWdata[MASK_LSB-1:6]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackQ <= '0;
    end else if (anyTake) begin
      stackQ <= {stackQ[3:0], 2'b00};
    end else if (str.doRet) begin
      stackQ <= {stackQ[5:4], stackQ[5:2]};
    end else if (str.wrStatus) begin
      stackQ <= regWdata[5:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '0;
      swPendQ <= '0;
    end else begin
      if (str.wrStatus) maskQ   <= regWdata[MASK_LSB +: MW];
      if (str.wrCause)  swPendQ <= regWdata[SWP_LSB +: SW];
    end
  end

  for (genvar g = 0; g < HW; g++) begin : gPend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hwPendQ[g] <= 1'b0;
      else       hwPendQ[g] <= (hwPendQ[g] & ~str.ackLine[g]) | hwIrq[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= '0;
      epcQ  <= '0;
      badQ  <= '0;
    end else if (anyTake) begin
      epcQ  <= instrPc;
      codeQ <= str.takeSync ? excCode : CW'(CODE_IRQ);
      if (str.takeSync && (excCode == CW'(CODE_ADR_LOAD) || excCode == CW'(CODE_ADR_STOR)))
        badQ <= faultAddr;
    end
  end

  always_comb begin
    statusWord                  = '0;
    statusWord[5:0]             = stackQ;
    statusWord[MASK_LSB +: MW]  = maskQ;
    causeWord                   = '0;
    causeWord[CODE_LSB +: CW]   = codeQ;
    causeWord[SWP_LSB +: SW]    = swPendQ;
    causeWord[HWP_LSB +: HW]    = hwPendQ;
  end

  always_comb begin
    case (regAddr)
      AW'(REG_BAD):    regRdata = badQ;
      AW'(REG_STATUS): regRdata = statusWord;
      AW'(REG_CAUSE):  regRdata = causeWord;
      AW'(REG_EPC):    regRdata = epcQ;
      default:         regRdata = '0;
    endcase
  end
endmodule

// File: rtl/trapCoproc.sv
module trapCoproc
  import excPkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          HW         = 5,
  parameter int          SW         = 2,
  parameter int          MW         = 8,
  parameter int          CW         = 4,
  parameter int          AW         = 5,
  parameter logic [31:0] HANDLER_PC = 32'h8000_0080
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            excReq,
  input  logic [CW-1:0]   excCode,
  input  logic [XLEN-1:0] instrPc,
  input  logic [XLEN-1:0] faultAddr,
  input  logic [HW-1:0]   hwIrq,
  input  logic            instrBoundary,
  input  logic            retExc,
  input  logic [AW-1:0]   regAddr,
  input  logic            regWe,
  input  logic [XLEN-1:0] regWdata,
  output logic [XLEN-1:0] regRdata,
  output logic            takeExc,
  output logic [XLEN-1:0] handlerPc,
  output logic            squashWb,
  output logic            userMode,
  output logic            intEn
);
  ctrlStrobes_t  str;
  logic [5:0]    stackQ;
  logic [MW-1:0] maskQ;
  logic [HW-1:0] hwPendQ;
  logic [SW-1:0] swPendQ;
  logic [CW-1:0] codeQ;
  logic          unusedMask;

  assign unusedMask = ^maskQ[MW-1:HW+SW];

  excControl #(.HW(HW), .SW(SW), .AW(AW)) u_ctrl (
    .excReq(excReq), .instrBoundary(instrBoundary), .retExc(retExc),
    .regWe(regWe), .regAddr(regAddr), .curEn(stackQ[0]),
    .maskLow(maskQ[HW+SW-1:0]), .hwPend(hwPendQ), .swPend(swPendQ),
    .str(str), .takeExc(takeExc)
  );

  excDatapath #(.XLEN(XLEN), .HW(HW), .SW(SW), .MW(MW), .CW(CW), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .excCode(excCode), .instrPc(instrPc),
    .faultAddr(faultAddr), .hwIrq(hwIrq), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .stackQ(stackQ), .maskQ(maskQ), .hwPendQ(hwPendQ),
    .swPendQ(swPendQ), .codeQ(codeQ)
  );

  assign handlerPc = HANDLER_PC;
  assign squashWb  = excReq;
  assign userMode  = stackQ[1];
  assign intEn     = stackQ[0];
endmodule

// File: rtl/trapCoprocChk.sv
module trapCoprocChk (
  input logic       clk,
  input logic       rstN,
  input logic       excReq,
  input logic [3:0] excCode,
  input logic       takeExc,
  input logic       squashWb,
  input logic       instrBoundary,
  input logic       retExc,
  input logic       userMode,
  input logic       intEn,
  input logic [5:0] stackQ,
  input logic [3:0] codeQ
);
  a_r2_entry_kernel: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> (!userMode && !intEn));

  a_r3_return_pop: assert property (@(posedge clk) disable iff (!rstN)
    (retExc && !takeExc) |=> (stackQ[1:0] == $past(stackQ[3:2])));

  a_r7_squash_takes: assert property (@(posedge clk) disable iff (!rstN)
    squashWb |-> takeExc);

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    (takeExc && !excReq) |-> (instrBoundary && intEn));

  a_r11_sync_code: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (codeQ == $past(excCode)));
endmodule

bind trapCoproc trapCoprocChk u_chk (
  .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode), .takeExc(takeExc),
  .squashWb(squashWb), .instrBoundary(instrBoundary), .retExc(retExc),
  .userMode(userMode), .intEn(intEn), .stackQ(stackQ), .codeQ(codeQ)
);

// File: tb/sim_trapCoproc.sv
`timescale 1ns/1ps
module sim_trapCoproc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [3:0]  excCode = '0;
  logic [31:0] instrPc = '0;
  logic [31:0] faultAddr = '0;
  logic [4:0]  hwIrq = '0;
  logic        instrBoundary = 1'b0;
  logic        retExc = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        takeExc;
  logic [31:0] handlerPc;
  logic        squashWb;
  logic        userMode;
  logic        intEn;

  int errors = 0;
  int checks = 0;
  logic [31:0] lastRd;

  // bench model state
  logic [5:0]  mStack = '0;
  logic [7:0]  mMask  = '0;
  logic [4:0]  mHw    = '0;
  logic [1:0]  mSw    = '0;
  logic [3:0]  mCode  = '0;
  logic [31:0] mEpc   = '0;
  logic [31:0] mBad   = '0;

  always #4 clk = ~clk;

  trapCoproc u0 (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode), .instrPc(instrPc),
    .faultAddr(faultAddr), .hwIrq(hwIrq), .instrBoundary(instrBoundary),
    .retExc(retExc), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .takeExc(takeExc), .handlerPc(handlerPc),
    .squashWb(squashWb), .userMode(userMode), .intEn(intEn)
  );

  function automatic logic [31:0] fRead(input logic [4:0] a);
    case (a)
      5'd8:    return mBad;
      5'd12:   return {16'b0, mMask, 2'b0, mStack};
      5'd13:   return {16'b0, 1'b0, mHw, mSw, 2'b0, mCode, 2'b0};
      5'd14:   return mEpc;
      default: return 32'b0;
    endcase
  endfunction

  function automatic string tagFor(input logic [4:0] a);
    case (a)
      5'd8:    return "R6";
      5'd12:   return "R2";
      5'd13:   return "R5";
      5'd14:   return "R4";
      default: return "R13";
    endcase
  endfunction

  function automatic logic fIrq(input logic ib, input logic ex);
    return ib && mStack[0] && (|({mHw, mSw} & mMask[6:0])) && !ex;
  endfunction

  function automatic logic [4:0] fAck();
    logic [4:0] r = '0;
    for (int i = 0; i < 5; i++) if (mHw[i] && mMask[2+i]) r = 5'(1) << i;
    return r;
  endfunction

  function automatic logic [3:0] codeAt(input int k);
    case (k % 8)
      0: return 4'd4;  1: return 4'd5;  2: return 4'd6;  3: return 4'd7;
      4: return 4'd8;  5: return 4'd9;  6: return 4'd10; default: return 4'd12;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic ex, input logic [3:0] cd, input logic [31:0] pc,
                     input logic [31:0] fa, input logic [4:0] hw, input logic ib,
                     input logic rt, input logic we, input logic [4:0] ad,
                     input logic [31:0] wd);
    logic irqW, tk;
    logic [4:0] ack;
    @(negedge clk);
    excReq = ex; excCode = cd; instrPc = pc; faultAddr = fa; hwIrq = hw;
    instrBoundary = ib; retExc = rt; regWe = we; regAddr = ad; regWdata = wd;
    #2;
    irqW = fIrq(ib, ex);
    tk   = ex | irqW;
    ack  = irqW ? fAck() : 5'b0;
    chk({31'b0, takeExc}, {31'b0, tk}, ex ? "R7 take" : "R8 take");
    chk({31'b0, squashWb}, {31'b0, ex}, "R7 squash");
    chk(handlerPc, 32'h8000_0080, "R4 handler");
    chk({30'b0, userMode, intEn}, {30'b0, mStack[1:0]}, "R2 mode");
    lastRd = regRdata;
    chk(regRdata, fRead(ad), tagFor(ad));
    @(posedge clk);
    if (tk)                         mStack = {mStack[3:0], 2'b00};
    else if (rt)                    mStack = {mStack[5:4], mStack[5:2]};
    else if (we && ad == 5'd12)     mStack = wd[5:0];
    if (!tk && we && ad == 5'd12)   mMask = wd[15:8];
    if (!tk && we && ad == 5'd13)   mSw = wd[9:8];
    mHw = (mHw & ~ack) | hw;
    if (tk) begin
      mEpc  = pc;
      mCode = ex ? cd : 4'd0;
      if (ex && (cd == 4'd4 || cd == 4'd5)) mBad = fa;
    end
  endtask

  task automatic idle(input logic [4:0] hw, input logic ib);
    cyc(1'b0, 4'd0, 32'h0, 32'h0, hw, ib, 1'b0, 1'b0, 5'd0, 32'h0);
  endtask

  task automatic wr(input logic [4:0] ad, input logic [31:0] wd);
    cyc(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, ad, wd);
  endtask

  task automatic rd(input logic [4:0] ad, input logic [31:0] exp, input string tag);
    cyc(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, ad, 32'h0);
    chk(lastRd, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd(5'd12, 32'h0, "R1 status");
    rd(5'd13, 32'h0, "R1 cause");
    rd(5'd14, 32'h0, "R1 epc");
    rd(5'd8,  32'h0, "R1 bad");
    chk({30'b0, userMode, intEn}, 32'h0, "R1 mode");

    // R12 status write keeps only mask and stack
    wr(5'd12, 32'hABCD_FF2D);
    rd(5'd12, 32'h0000_FF2D, "R12 status mask");
    wr(5'd12, 32'h0000_FF00);

    // R8/R9 lines 2 and 4 rise while disabled: not taken, stay pending
    idle(5'b10100, 1'b1);
    idle(5'b00000, 1'b1);
    chk({31'b0, takeExc}, 32'h0, "R8 disabled no take");
    rd(5'd13, 32'h0000_5000, "R9 sticky pending");

    // R10 enable, take at boundary, line 4 acknowledged
    wr(5'd12, 32'h0000_FF01);
    idle(5'b00000, 1'b1);
    rd(5'd13, 32'h0000_1000, "R10 ack highest line");
    rd(5'd12, 32'h0000_FF04, "R2 entry shift");

    // R11 + R3: exception, interrupt and return all in one cycle
    wr(5'd12, 32'h0000_FF05);
    cyc(1'b1, 4'd9, 32'h0000_0100, 32'h0, 5'd0, 1'b1, 1'b1, 1'b0, 5'd0, 32'h0);
    rd(5'd12, 32'h0000_FF14, "R3 return ignored on take");
    rd(5'd13, 32'h0000_1024, "R11 sync wins, line kept");
    rd(5'd14, 32'h0000_0100, "R4 epc");

    // R3 plain return
    cyc(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 5'd0, 32'h0);
    rd(5'd12, 32'h0000_FF15, "R3 pop");

    // R6 bad address capture only for codes 4/5
    cyc(1'b1, 4'd4, 32'h0040_0100, 32'hDEAD_0004, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0);
    rd(5'd8,  32'hDEAD_0004, "R6 capture");
    rd(5'd14, 32'h0040_0100, "R4 epc load");
    cyc(1'b1, 4'd8, 32'h0040_0200, 32'h0000_1111, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0);
    rd(5'd8,  32'hDEAD_0004, "R6 hold on syscall");
    rd(5'd13, 32'h0000_1020, "R5 syscall code");

    // R12 read-only registers and cause write mask
    wr(5'd14, 32'h0);
    rd(5'd14, 32'h0040_0200, "R12 epc not writable");
    wr(5'd8, 32'h0);
    rd(5'd8, 32'hDEAD_0004, "R12 bad not writable");
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, 32'h0000_1320, "R12 cause sw bits only");
    rd(5'd3, 32'h0, "R13 unmapped reads zero");

    // random traffic checked against the model
    for (int n = 0; n < 3000; n++) begin
      logic ex, ib, rt, we;
      logic [4:0] ad, hw;
      ex = ($urandom % 8) == 0;
      ib = ($urandom % 2) == 0;
      rt = ($urandom % 8) == 0;
      we = ($urandom % 6) == 0;
      hw = 5'($urandom) & 5'($urandom) & 5'($urandom);
      case ($urandom % 6)
        0: ad = 5'd8; 1: ad = 5'd12; 2: ad = 5'd13; 3: ad = 5'd14;
        default: ad = 5'($urandom);
      endcase
      cyc(ex, codeAt(int'($urandom % 8)), $urandom, $urandom, hw, ib, rt, we, ad, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule